// File: doc/BRIEF.md
# Energy-Detect Power-Down Controller

This block runs a low-power mode for a network PHY datapath. While the mode is enabled and the line carries no energy, it switches off the power rail of the transmit and receive datapath and blocks transmission. The management interface, the squelch circuit and the energy sensing logic stay on a supply this block never gates. When energy returns, the block powers the datapath back up. It holds transmission off for a fixed settling window, then hands the datapath the state it had saved on the way down. It also sets a sticky wake flag, and that flag raises a host interrupt when the interrupt is unmasked.

The energy indication arrives from the analog front end without a clock relation, so it is resynchronized before any decision uses it. Software leaves the mode by clearing the enable bit. If it does so while the datapath is asleep, the datapath wakes at once and the wake flag is not touched. Frames that arrive while the datapath is still waking may be lost. The block makes no attempt to recover them.

Top module: `lpd_ctrl`

## Requirements
- R1: While `sleep_en` is 0, `pwr_en` stays 1 whatever `line_energy` does.
- R2: With `sleep_en` at 1, a low `line_energy` passes through a two-stage synchronizer. The datapath enters sleep on the third rising edge after the low level is applied. In sleep `pwr_en` is 0 and `tx_inhibit` is 1.
- R3: In sleep, a high `line_energy` turns `pwr_en` back to 1 on the third rising edge. `tx_inhibit` then stays 1 for `SETTLE_CYC` cycles (default 4) and clears on the following edge.
- R4: `dp_state` is captured into `restore_state` on the edge that enters sleep, and it is held unchanged through sleep. `restore_load` is 1 for exactly the first awake cycle after any wake. In that cycle `restore_state` still carries the captured value.
- R5: The edge that ends an energy wake sets `wake_flag`. The flag stays 1 until the edge that samples `flag_clr` at 1. When a set and a clear land on the same edge, the set wins.
- R6: `wake_irq` equals `wake_flag` AND `wake_irq_en`. The mask bit never changes the flag.
- R7: Clearing `sleep_en` while asleep wakes the datapath on the next edge, with no settling window. `restore_load` pulses as in R4, and `wake_flag` is not set.
- R8: After reset, `pwr_en` is 1 and `tx_inhibit`, `wake_flag`, `wake_irq`, `restore_load` and `restore_state` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Enables the energy-detect power-down mode |
| line_energy | input | 1 | Asynchronous line-energy indication |
| wake_irq_en | input | 1 | Unmasks the wake interrupt |
| flag_clr | input | 1 | Host strobe that clears the wake flag |
| dp_state | input | SW | Live datapath state to be saved |
| pwr_en | output | 1 | Datapath power rail enable |
| tx_inhibit | output | 1 | Blocks transmission |
| wake_flag | output | 1 | Sticky energy-wake flag |
| wake_irq | output | 1 | Host interrupt request |
| restore_load | output | 1 | One-cycle pulse that reloads the saved state |
| restore_state | output | SW | Saved datapath state |

## Verification
The hardest case to reach is a host clear that arrives on the same edge as the end of an energy wake. The bench counts edges from the moment energy returns, through the synchronizer and the settling window. It then asserts `flag_clr` in exactly the cycle before wake completion, while the interrupt is masked. The forced wake is reached by putting the datapath to sleep with a fresh state value and then dropping the enable bit instead of restoring energy. This shows that the saved state comes back without any change to the flag.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  typedef enum logic [1:0] {
    PS_AWAKE  = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_WAKING = 2'd2
  } pstate_e;

  function automatic pstate_e pd_next(pstate_e s, logic en, logic energy, logic settled);
    pstate_e n;
    case (s)
      PS_AWAKE:  n = (en && !energy) ? PS_SLEEP : PS_AWAKE;
      PS_SLEEP:  n = !en ? PS_AWAKE : (energy ? PS_WAKING : PS_SLEEP);
      PS_WAKING: n = settled ? PS_AWAKE : PS_WAKING;
      default:   n = PS_AWAKE;
    endcase
    return n;
  endfunction

  function automatic logic pd_rail_on(pstate_e s);
    return s != PS_SLEEP;
  endfunction

  function automatic logic pd_tx_block(pstate_e s);
    return s != PS_AWAKE;
  endfunction

endpackage

// File: rtl/lpd_sync.sv
module lpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/lpd_settle.sv
module lpd_settle #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
endmodule

// File: rtl/lpd_flag.sv
module lpd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
endmodule

// File: rtl/lpd_ctrl.sv
module lpd_ctrl
  import lpd_pkg::*;
#(
  parameter int SW         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_en,
  input  logic          line_energy,
  input  logic          wake_irq_en,
  input  logic          flag_clr,
  input  logic [SW-1:0] dp_state,
  output logic          pwr_en,
  output logic          tx_inhibit,
  output logic          wake_flag,
  output logic          wake_irq,
  output logic          restore_load,
  output logic [SW-1:0] restore_state
);
  pstate_e st, st_nx;
  logic    energy_s;
  logic    settle_run;
  logic    wake_done;
  logic    force_wake;
  logic    enter_sleep;
  logic    rl_q;
  logic [SW-1:0] saved_q;

  lpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_energy), .q(energy_s)
  );

  assign settle_run = (st == PS_WAKING);

  lpd_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(settle_run), .done(wake_done)
  );

  assign force_wake  = (st == PS_SLEEP) && !sleep_en;
  assign enter_sleep = (st == PS_AWAKE) && sleep_en && !energy_s;
  assign st_nx       = pd_next(st, sleep_en, energy_s, wake_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= PS_AWAKE;
      saved_q <= '0;
      rl_q    <= 1'b0;
    end else begin
      st   <= st_nx;
      rl_q <= wake_done || force_wake;
      if (enter_sleep) saved_q <= dp_state;
    end

  lpd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(wake_done), .clr(flag_clr), .q(wake_flag)
  );

  assign pwr_en        = pd_rail_on(st);
  assign tx_inhibit    = pd_tx_block(st);
  assign wake_irq      = wake_flag && wake_irq_en;
  assign restore_load  = rl_q;
  assign restore_state = saved_q;
endmodule

// File: rtl/lpd_ctrl_chk.sv
module lpd_ctrl_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_en,
  input logic          wake_irq_en,
  input logic          flag_clr,
  input logic          pwr_en,
  input logic          tx_inhibit,
  input logic          wake_flag,
  input logic          wake_irq,
  input logic          restore_load,
  input logic [SW-1:0] restore_state,
  input logic          wake_done,
  input logic          force_wake
);
  p_stay_on_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_en && pwr_en) |=> pwr_en);

  p_off_blocks_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> tx_inhibit);

  p_saved_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> $stable(restore_state));

  p_restore_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_load |-> (pwr_en && !tx_inhibit));

  p_flag_on_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> wake_flag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !flag_clr) |=> wake_flag);

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_irq_en |-> !wake_irq);

  p_forced_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_wake && !wake_flag) |=> (!wake_flag && restore_load && pwr_en));
endmodule

bind lpd_ctrl lpd_ctrl_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .wake_irq_en(wake_irq_en),
  .flag_clr(flag_clr), .pwr_en(pwr_en), .tx_inhibit(tx_inhibit),
  .wake_flag(wake_flag), .wake_irq(wake_irq), .restore_load(restore_load),
  .restore_state(restore_state), .wake_done(wake_done), .force_wake(force_wake)
);

// File: tb/tb_lpd_ctrl.sv
module tb_lpd_ctrl;
  localparam int SW = 8;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n, sleep_en, line_energy, wake_irq_en, flag_clr;
  logic [SW-1:0] dp_state;
  logic pwr_en, tx_inhibit, wake_flag, wake_irq, restore_load;
  logic [SW-1:0] restore_state;

  always #5 clk = ~clk;

  lpd_ctrl #(.SW(SW), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .line_energy(line_energy),
    .wake_irq_en(wake_irq_en), .flag_clr(flag_clr), .dp_state(dp_state),
    .pwr_en(pwr_en), .tx_inhibit(tx_inhibit), .wake_flag(wake_flag),
    .wake_irq(wake_irq), .restore_load(restore_load), .restore_state(restore_state)
  );

  typedef struct {
    int           cyc;
    string        tag;
    logic         pwr, txi, flg, irq, rl;
    logic [SW-1:0] rs;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Driver side: queue what the ports must show n edges from now.
  task automatic expect_in(int n, string tag, logic pwr, logic txi, logic flg,
                           logic irq, logic rl, logic [SW-1:0] rs);
    exp_t e;
    e.cyc = cyc + n; e.tag = tag;
    e.pwr = pwr; e.txi = txi; e.flg = flg; e.irq = irq; e.rl = rl; e.rs = rs;
    q.push_back(e);
  endtask

  // Monitor side: compare away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc ||
          {pwr_en, tx_inhibit, wake_flag, wake_irq, restore_load} !== {e.pwr, e.txi, e.flg, e.irq, e.rl} ||
          restore_state !== e.rs) begin
        errors++;
        $display("FAIL %s cyc %0d: got pwr=%b txi=%b flag=%b irq=%b rl=%b rs=%h exp pwr=%b txi=%b flag=%b irq=%b rl=%b rs=%h (due %0d)",
                 e.tag, cyc, pwr_en, tx_inhibit, wake_flag, wake_irq, restore_load, restore_state,
                 e.pwr, e.txi, e.flg, e.irq, e.rl, e.rs, e.cyc);
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cyc %0d, expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_en = 1'b0; line_energy = 1'b1;
    wake_irq_en = 1'b0; flag_clr = 1'b0; dp_state = '0;
    tick(3);
    rst_n = 1'b1;
    expect_in(1, "R8 reset state", 1, 0, 0, 0, 0, 8'h00);
    tick(3);

    // R1: mode disabled, energy gone: stays powered
    line_energy = 1'b0;
    expect_in(6, "R1 disabled stays on", 1, 0, 0, 0, 0, 8'h00);
    tick(8);

    // R2: enter sleep through the synchronizer
    line_energy = 1'b1;
    tick(4);
    sleep_en = 1'b1;
    tick(2);
    dp_state = 8'hA5;
    line_energy = 1'b0;
    expect_in(2, "R2 sync delay still on", 1, 0, 0, 0, 0, 8'h00);
    expect_in(3, "R2 asleep", 0, 1, 0, 0, 0, 8'hA5);
    tick(4);
    dp_state = 8'h3C;
    expect_in(2, "R4 saved held in sleep", 0, 1, 0, 0, 0, 8'hA5);
    tick(3);

    // R3/R4/R5: energy wake with interrupt unmasked
    wake_irq_en = 1'b1;
    line_energy = 1'b1;
    expect_in(2, "R3 still off", 0, 1, 0, 0, 0, 8'hA5);
    expect_in(3, "R3 power up inhibited", 1, 1, 0, 0, 0, 8'hA5);
    expect_in(3 + SETTLE - 1, "R3 settling", 1, 1, 0, 0, 0, 8'hA5);
    expect_in(3 + SETTLE, "R4 restore pulse", 1, 0, 1, 1, 1, 8'hA5);
    expect_in(4 + SETTLE, "R4 pulse one cycle", 1, 0, 1, 1, 0, 8'hA5);
    tick(10);

    expect_in(3, "R5 flag sticky", 1, 0, 1, 1, 0, 8'hA5);
    tick(4);
    wake_irq_en = 1'b0;
    expect_in(1, "R6 masked irq low flag kept", 1, 0, 1, 0, 0, 8'hA5);
    tick(2);
    flag_clr = 1'b1;
    expect_in(1, "R5 clear strobe", 1, 0, 0, 0, 0, 8'hA5);
    tick(1);
    flag_clr = 1'b0;
    tick(2);

    // R5: set beats a simultaneous clear; R6: flag set while masked
    dp_state = 8'h5A;
    line_energy = 1'b0;
    tick(4);
    line_energy = 1'b1;
    expect_in(3 + SETTLE, "R5 set wins over clear", 1, 0, 1, 0, 1, 8'h5A);
    tick(2 + SETTLE);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    tick(3);
    wake_irq_en = 1'b1;
    expect_in(1, "R6 unmask raises irq", 1, 0, 1, 1, 0, 8'h5A);
    tick(2);

    // R7: forced wake by clearing the enable bit
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    dp_state = 8'h77;
    line_energy = 1'b0;
    expect_in(3, "R7 asleep before force", 0, 1, 0, 0, 0, 8'h77);
    tick(4);
    sleep_en = 1'b0;
    expect_in(1, "R7 forced wake no flag", 1, 0, 0, 0, 1, 8'h77);
    expect_in(2, "R7 pulse ends", 1, 0, 0, 0, 0, 8'h77);
    tick(4);

    expect_in(5, "R1 stays on after force", 1, 0, 0, 0, 0, 8'h77);
    tick(7);

    while (q.size() > 0) tick(1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule